// File: doc/BRIEF.md
# Least-Recently-Used Flash Line Cache

This block is a small, fully associative, read-only store that sits next to a flash memory. It keeps copies of flash lines that recently missed, so that repeated reads of those lines do not have to wait for the flash. Each line is 256 bits wide and holds four 64-bit words. The number of lines is a parameter. An instruction-side instance is built with 32 lines and a data-side instance with 8. A lookup presents a 64-bit word address. If the line holding that word is present, the block answers in the same cycle with a hit and the selected word.

When the flash controller fetches a line after a miss, it offers the line on the fill port. The block stores the line in a free slot. When every slot is valid, the block overwrites the slot that was used least recently. Hits and fills both count as uses. Requests from a non-CPU master bypass the cache, and so do requests flagged as non-cacheable (the option-byte region). Such requests never hit and never allocate.

An enable bit, which is set at reset, gates the whole function. Clearing the bit leaves the stored lines intact. A flush input drops every line at once. Flash timing and bus arbitration are handled outside this block.

Top module: `flash_line_cache`

## Requirements
- R1: After reset the cache is enabled and holds no valid line, so every lookup misses until a line is filled.
- R2: A lookup of a stored line raises `lk_hit` and drives `lk_data` combinationally in the same cycle as the address, with no wait cycle.
- R3: An accepted fill takes the lowest-numbered invalid slot while one exists, and a lookup of a line that was never filled misses.
- R4: When all slots are valid, an accepted fill of a new line replaces the least recently used line. Both hits and fills make a line the most recently used.
- R5: A fill whose line address is already stored overwrites that slot's data in place and evicts no other line.
- R6: With `lk_cpu` low, a lookup misses. With `fill_cpu` low, a fill changes nothing.
- R7: With `lk_nc` high, a lookup misses. With `fill_nc` high, a fill changes nothing.
- R8: The enable bit is written from `cfg_en` on a cycle where `cfg_we` is high. While the bit is clear, lookups miss and fills are ignored. Setting it again restores the earlier contents.
- R9: A pulse on `flush` invalidates every line from the next cycle on, and a fill in the same cycle is dropped.
- R10: Word k of a line (k = `lk_addr[1:0]`) is bits [64k+63:64k] of `fill_data`. The line address is `lk_addr[WADDR_W-1:2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the enable bit |
| cfg_en | input | 1 | New value of the enable bit |
| flush | input | 1 | Invalidate all lines |
| lk_valid | input | 1 | Lookup request present |
| lk_cpu | input | 1 | Lookup comes from the CPU |
| lk_nc | input | 1 | Lookup address is non-cacheable |
| lk_addr | input | WADDR_W | 64-bit word address of the lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_data | output | 64 | Word returned on a hit |
| fill_valid | input | 1 | Fill line present |
| fill_cpu | input | 1 | Fill belongs to a CPU request |
| fill_nc | input | 1 | Fill address is non-cacheable |
| fill_line | input | WADDR_W-2 | Line address of the fill |
| fill_data | input | 256 | Four 64-bit words of the line |

## Verification
The bench reads different word offsets of several lines. This separates correct word selection from an off-by-one lane and shows that the data comes from the right slot. It then fills past capacity after a mix of hits. That pattern distinguishes true recency order from fill-order (FIFO) replacement, because a line that was hit early must survive while a line that was never hit is evicted. The bench also re-fills a line that is already present, to catch duplicate allocation. Finally, it repeats lookups and fills with the requester, non-cacheable, enable and flush controls set one at a time, each followed by normal lookups that show whether the stored state was left alone.

// File: rtl/flash_line_cache.sv
module flash_line_cache #(
  parameter int LINES   = 8,
  parameter int WADDR_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_en,
  input  logic               flush,
  input  logic               lk_valid,
  input  logic               lk_cpu,
  input  logic               lk_nc,
  input  logic [WADDR_W-1:0] lk_addr,
  output logic               lk_hit,
  output logic [63:0]        lk_data,
  input  logic               fill_valid,
  input  logic               fill_cpu,
  input  logic               fill_nc,
  input  logic [WADDR_W-3:0] fill_line,
  input  logic [255:0]       fill_data
);
  localparam int AGE_W = $clog2(LINES);
  localparam int TAG_W = WADDR_W - 2;

  logic               on;
  logic [LINES-1:0]   vld;
  logic [TAG_W-1:0]   tag [LINES];
  logic [255:0]       dat [LINES];
  logic [AGE_W-1:0]   age [LINES];
  logic [LINES-1:0]   lk_match, fl_match, oldest;
  logic [AGE_W-1:0]   hit_idx, vic, tidx;
  logic [255:0]       line;
  logic               lk_go, fl_go, touch;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign lk_match[g] = vld[g] && tag[g] == lk_addr[WADDR_W-1:2];
    assign fl_match[g] = vld[g] && tag[g] == fill_line;
    assign oldest[g]   = age[g] == AGE_W'(LINES-1);
  end

  assign lk_go  = lk_valid && on && lk_cpu && !lk_nc;
  assign lk_hit = lk_go && |lk_match;
  assign fl_go  = fill_valid && on && fill_cpu && !fill_nc && !flush;
  assign touch  = fl_go || lk_hit;
  assign tidx   = fl_go ? vic : hit_idx;

  always_comb begin
    line    = '0;
    hit_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (lk_match[i]) begin
        line    = dat[i];
        hit_idx = AGE_W'(i);
      end
    lk_data = line[{lk_addr[1:0], 6'b0} +: 64];
  end

  always_comb begin
    vic = '0;
    if (|fl_match) begin
      for (int i = 0; i < LINES; i++)
        if (fl_match[i]) vic = AGE_W'(i);
    end else if (&vld) begin
      for (int i = 0; i < LINES; i++)
        if (oldest[i]) vic = AGE_W'(i);
    end else begin
      for (int i = LINES - 1; i >= 0; i--)
        if (!vld[i]) vic = AGE_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on  <= 1'b1;
      vld <= '0;
      for (int i = 0; i < LINES; i++) begin
        age[i] <= AGE_W'(i);
        tag[i] <= '0;
        dat[i] <= '0;
      end
    end else begin
      if (cfg_we) on <= cfg_en;
      if (flush) vld <= '0;
      else if (fl_go) begin
        vld[vic] <= 1'b1;
        tag[vic] <= fill_line;
        dat[vic] <= fill_data;
      end
      if (touch)
        for (int i = 0; i < LINES; i++)
          if (AGE_W'(i) == tidx) age[i] <= '0;
          else if (age[i] < age[tidx]) age[i] <= age[i] + 1'b1;
    end
  end
endmodule

module flash_line_cache_chk #(
  parameter int LINES   = 8,
  parameter int WADDR_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               on,
  input logic               flush,
  input logic               fl_go,
  input logic               lk_valid,
  input logic               lk_cpu,
  input logic               lk_nc,
  input logic [WADDR_W-1:0] lk_addr,
  input logic               lk_hit,
  input logic [WADDR_W-3:0] fill_line,
  input logic [LINES-1:0]   oldest
);
  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fl_go) && on && lk_valid && lk_cpu && !lk_nc && !$past(flush) &&
     lk_addr[WADDR_W-1:2] == $past(fill_line)) |-> lk_hit); // R2
  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1); // R4
  AST_CPU_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_valid && lk_cpu)); // R6
  AST_NC_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !lk_nc); // R7
  AST_OFF_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !on |-> !lk_hit); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit); // R9
endmodule

bind flash_line_cache flash_line_cache_chk #(.LINES(LINES), .WADDR_W(WADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .on(on), .flush(flush), .fl_go(fl_go),
  .lk_valid(lk_valid), .lk_cpu(lk_cpu), .lk_nc(lk_nc), .lk_addr(lk_addr),
  .lk_hit(lk_hit), .fill_line(fill_line), .oldest(oldest)
);

// File: tb/flash_line_cache_test.sv
module flash_line_cache_test;
  localparam int LINES = 4;
  localparam int WA    = 20;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_en = 0, flush = 0;
  logic lk_valid = 0, lk_cpu = 1, lk_nc = 0;
  logic [WA-1:0] lk_addr = '0;
  logic lk_hit;
  logic [63:0] lk_data;
  logic fill_valid = 0, fill_cpu = 1, fill_nc = 0;
  logic [WA-3:0] fill_line = '0;
  logic [255:0] fill_data = '0;

  int tests = 0, fails = 0;
  bit done = 0;

  typedef struct { bit hit; logic [63:0] data; string req; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  flash_line_cache #(.LINES(LINES), .WADDR_W(WA)) uut (.*);

  function automatic logic [255:0] mk(int t, int salt);
    logic [255:0] v;
    for (int k = 0; k < 4; k++) v[64*k +: 64] = {32'(t + salt), 32'(k)};
    return v;
  endfunction

  task automatic look(int t, int w, bit cpu, bit nc, bit eh, int salt, string req);
    exp_t e;
    @(negedge clk);
    lk_valid = 1; lk_cpu = cpu; lk_nc = nc; lk_addr = {18'(t), 2'(w)};
    e.hit = eh; e.data = {32'(t + salt), 32'(w)}; e.req = req;
    q.push_back(e);
    @(negedge clk);
    lk_valid = 0; lk_cpu = 1; lk_nc = 0;
  endtask

  task automatic fill(int t, bit cpu, bit nc, int salt);
    @(negedge clk);
    fill_valid = 1; fill_cpu = cpu; fill_nc = nc; fill_line = 18'(t); fill_data = mk(t, salt);
    @(negedge clk);
    fill_valid = 0; fill_cpu = 1; fill_nc = 0;
  endtask

  task automatic set_en(bit v);
    @(negedge clk); cfg_we = 1; cfg_en = v;
    @(negedge clk); cfg_we = 0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk); #3;
      if (q.size() != 0) begin
        e = q.pop_front();
        tests++;
        if (lk_hit !== e.hit || (e.hit && lk_data !== e.data)) begin
          fails++;
          $display("FAIL %s: hit=%0b data=%h expected hit=%0b data=%h", e.req, lk_hit, lk_data, e.hit, e.data);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(5, 0, 1, 0, 0, 0, "R1 empty after reset");
    fill(1, 1, 0, 0); fill(2, 1, 0, 0); fill(3, 1, 0, 0); fill(4, 1, 0, 0);
    look(1, 2, 1, 0, 1, 0, "R2 R10 word 2 of line 1");
    look(3, 3, 1, 0, 1, 0, "R2 R10 word 3 of line 3");
    look(2, 0, 1, 0, 1, 0, "R3 R10 word 0 of line 2");
    look(9, 1, 1, 0, 0, 0, "R3 unfilled line misses");
    // recency now newest->oldest: 2,3,1,4
    fill(5, 1, 0, 0); // evicts 4
    look(4, 0, 1, 0, 0, 0, "R4 LRU line 4 evicted");
    look(1, 1, 1, 0, 1, 0, "R4 line 1 kept");
    // order: 1,5,2,3
    fill(6, 1, 0, 0); // evicts 3
    look(3, 0, 1, 0, 0, 0, "R4 LRU line 3 evicted");
    look(2, 0, 1, 0, 1, 0, "R4 line 2 kept");
    look(5, 0, 1, 0, 1, 0, "R4 line 5 kept");
    // present: 1,2,5,6
    fill(6, 1, 0, 100);
    look(6, 1, 1, 0, 1, 100, "R5 in-place refill data");
    look(1, 0, 1, 0, 1, 0, "R5 line 1 not evicted");
    look(2, 3, 1, 0, 1, 0, "R5 line 2 not evicted");
    look(5, 2, 1, 0, 1, 0, "R5 line 5 not evicted");
    look(1, 0, 0, 0, 0, 0, "R6 non-CPU lookup misses");
    fill(7, 0, 0, 0);
    look(7, 0, 1, 0, 0, 0, "R6 non-CPU fill ignored");
    look(6, 0, 1, 0, 1, 100, "R6 contents intact");
    look(2, 0, 1, 1, 0, 0, "R7 non-cacheable lookup misses");
    fill(8, 1, 1, 0);
    look(8, 0, 1, 0, 0, 0, "R7 non-cacheable fill ignored");
    look(1, 0, 1, 0, 1, 0, "R7 contents intact");
    set_en(0);
    look(1, 0, 1, 0, 0, 0, "R8 disabled lookup misses");
    fill(9, 1, 0, 0);
    set_en(1);
    look(9, 0, 1, 0, 0, 0, "R8 disabled fill ignored");
    look(5, 3, 1, 0, 1, 0, "R8 contents kept after re-enable");
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    look(1, 0, 1, 0, 0, 0, "R9 flushed line 1");
    look(5, 0, 1, 0, 0, 0, "R9 flushed line 5");
    fill(10, 1, 0, 0);
    look(10, 2, 1, 0, 1, 0, "R9 R3 fill after flush");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule